// File: doc/BRIEF.md
# Timer Compare Channel with Buffered Compare Value

This block is one compare channel of a 16-bit timer. Software sets its compare value through an 8-bit bus: the upper byte goes first into a shared holding byte, and writing the lower byte then commits the whole 16-bit word in a single step. On every timer tick the block compares the running count with its active compare value. It produces a registered match pulse for a downstream waveform generator, a sticky compare flag that is set one tick after the equality, and an interrupt request that the flag raises when interrupts are enabled.

In the two direct modes (free-running and clear-on-match) a committed word becomes the active compare value at once. In the two PWM modes a committed word waits in a shadow register. It moves into the active register only when the counter reports its top or bottom point, and the mode selects which of the two. This keeps each PWM period free of odd-length pulses. The active value is also exported as a registered top value, so this channel can set the counter's period.

Top module: `tcmp_channel`

## Requirements
- R1: After reset the active value, shadow, holding byte, flag, match pulse and exported top value are all zero.
- R2: A bus write to address 1 only loads the holding byte and leaves the active compare value unchanged.
- R3: In modes 0 and 1 (free-running, clear-on-match), a write to address 0 makes {holding byte, written byte} the active value on the next clock.
- R4: In mode 2 a committed word reaches the active value only on a clock where tick and top_strobe are both high. In mode 3 this happens only where tick and bottom_strobe are both high. At all other times the active value holds.
- R5: match_pulse is high for exactly the clock after a cycle in which tick is high and count equals the active value.
- R6: The flag is set on the next tick after the tick that saw equality.
- R7: irq is high exactly when the flag is set and irq_en is high.
- R8: The flag is cleared by irq_ack, or by a bus write to address 2 with data bit 0 set. A write there with bit 0 clear has no effect.
- R9: When a flag set and a flag clear fall in the same cycle, the flag ends up set.
- R10: When a commit and a PWM load point fall in the same cycle, the active register takes the old shadow value and the shadow takes the new word. The new word becomes active at the following load point.
- R11: top_value equals the active value, delayed by one clock.
- R12: While bus_rd is high, bus_rdata returns the active low byte at address 0, the active high byte at address 1, the flag in bit 0 at address 2, and zero at address 3. While bus_rd is low it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable |
| cnt_val | input | 16 | Running counter value |
| top_strobe | input | 1 | Counter is at its top point |
| bottom_strobe | input | 1 | Counter is at its bottom point |
| mode_sel | input | 2 | 0 free-running, 1 clear-on-match, 2 PWM load at top, 3 PWM load at bottom |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag, 3 unused |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt serviced, clears flag |
| irq | output | 1 | Interrupt request |
| match_pulse | output | 1 | Registered equality pulse |
| top_value | output | 16 | Registered active compare value for use as period |

## Verification
Two pairs of events can fall in the same cycle. The first is a low-byte commit landing on a PWM load point. The second is a flag set landing on the same clock as an acknowledge or a write-one clear. Directed sequences force each pair: a commit is placed on the strobe cycle, and an acknowledge is placed on the tick that follows a match. The bench then judges the outcome by reading back the active value over the bus and watching the flag, both before and after the next load point. Random traffic, with the count often steered onto the active value, provokes the same collisions many more times. A bench model that applies the stated priorities predicts every cycle.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR     = 2'd1,
    MODE_PWM_TOP = 2'd2,
    MODE_PWM_BOT = 2'd3
  } cmp_mode_e;

  localparam logic [1:0] REG_LO   = 2'd0;
  localparam logic [1:0] REG_HI   = 2'd1;
  localparam logic [1:0] REG_FLAG = 2'd2;
  localparam logic [1:0] REG_RSVD = 2'd3;

  // PWM modes are the buffered ones
  function automatic logic mode_buffered(cmp_mode_e m);
    return (m == MODE_PWM_TOP) || (m == MODE_PWM_BOT);
  endfunction

  // Shadow-to-active transfer point for the given mode
  function automatic logic load_point(cmp_mode_e m, logic tk, logic at_top, logic at_bot);
    logic r;
    case (m)
      MODE_PWM_TOP: r = tk && at_top;
      MODE_PWM_BOT: r = tk && at_bot;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

  // Flag next-state: a set beats a clear
  function automatic logic flag_next(logic cur, logic set_i, logic clr_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return cur;
  endfunction

endpackage

// File: rtl/tcmp_bus_port.sv
module tcmp_bus_port #(
  parameter int BUS_W = 8,
  localparam int VAL_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic             commit_stb,
  output logic [VAL_W-1:0] commit_val,
  output logic             flag_wr1
);
  import tcmp_pkg::*;

  logic [BUS_W-1:0] hold_q;

  // Upper byte is parked until the lower byte arrives
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (bus_wr && bus_addr == REG_HI) hold_q <= bus_wdata;
  end

  assign commit_stb = bus_wr && (bus_addr == REG_LO);
  assign commit_val = {hold_q, bus_wdata};
  assign flag_wr1   = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

endmodule

// File: rtl/tcmp_value_store.sv
module tcmp_value_store #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buffered,
  input  logic             load_evt,
  input  logic             commit_stb,
  input  logic [VAL_W-1:0] commit_val,
  output logic [VAL_W-1:0] active_q,
  output logic [VAL_W-1:0] shadow_q
);

  // Shadow always tracks committed words; in direct modes the active
  // register takes the same word, in buffered modes it waits for load_evt.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (commit_stb) shadow_q <= commit_val;
      if (buffered) begin
        if (load_evt) active_q <= shadow_q;
      end else if (commit_stb) begin
        active_q <= commit_val;
      end
    end
  end

endmodule

// File: rtl/tcmp_match_unit.sv
module tcmp_match_unit #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VAL_W-1:0] cnt_val,
  input  logic [VAL_W-1:0] active_val,
  output logic             match_pulse,
  output logic             flag_set
);

  logic equal;
  logic seen_q;

  assign equal = (cnt_val == active_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      seen_q      <= 1'b0;
    end else begin
      match_pulse <= tick && equal;
      if (tick) seen_q <= equal;
    end
  end

  // Equality observed on the previous tick sets the flag on this tick
  assign flag_set = tick && seen_q;

endmodule

// File: rtl/tcmp_flag_ctl.sv
module tcmp_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_set,
  input  logic irq_ack,
  input  logic flag_wr1,
  input  logic irq_en,
  output logic flag_q,
  output logic irq
);
  import tcmp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, flag_set, irq_ack || flag_wr1);
  end

  assign irq = flag_q && irq_en;

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int BUS_W      = 8,
  parameter bit EXPORT_TOP = 1'b1,
  localparam int VAL_W     = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [VAL_W-1:0] cnt_val,
  input  logic             top_strobe,
  input  logic             bottom_strobe,
  input  logic [1:0]       mode_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             irq_en,
  input  logic             irq_ack,
  output logic             irq,
  output logic             match_pulse,
  output logic [VAL_W-1:0] top_value
);
  import tcmp_pkg::*;

  cmp_mode_e        mode;
  logic             buffered;
  logic             load_evt;
  logic             commit_stb;
  logic [VAL_W-1:0] commit_val;
  logic             flag_wr1;
  logic [VAL_W-1:0] active_val;
  logic [VAL_W-1:0] shadow_val;
  logic             flag_set;
  logic             flag_q;

  assign mode     = cmp_mode_e'(mode_sel);
  assign buffered = mode_buffered(mode);
  assign load_evt = load_point(mode, tick, top_strobe, bottom_strobe);

  tcmp_bus_port #(.BUS_W(BUS_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .commit_stb (commit_stb),
    .commit_val (commit_val),
    .flag_wr1   (flag_wr1)
  );

  tcmp_value_store #(.VAL_W(VAL_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .buffered   (buffered),
    .load_evt   (load_evt),
    .commit_stb (commit_stb),
    .commit_val (commit_val),
    .active_q   (active_val),
    .shadow_q   (shadow_val)
  );

  tcmp_match_unit #(.VAL_W(VAL_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cnt_val     (cnt_val),
    .active_val  (active_val),
    .match_pulse (match_pulse),
    .flag_set    (flag_set)
  );

  tcmp_flag_ctl u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_set (flag_set),
    .irq_ack  (irq_ack),
    .flag_wr1 (flag_wr1),
    .irq_en   (irq_en),
    .flag_q   (flag_q),
    .irq      (irq)
  );

  // Read-back of the active word and the flag
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_LO:   bus_rdata = active_val[BUS_W-1:0];
        REG_HI:   bus_rdata = active_val[VAL_W-1:BUS_W];
        REG_FLAG: bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  generate
    if (EXPORT_TOP) begin : g_top
      logic [VAL_W-1:0] top_q;
      always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= active_val;
      end
      assign top_value = top_q;
    end else begin : g_no_top
      assign top_value = '0;
    end
  endgenerate

endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
  parameter int BUS_W      = 8,
  parameter bit EXPORT_TOP = 1'b1,
  localparam int VAL_W     = 2 * BUS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [VAL_W-1:0] cnt_val,
  input logic [1:0]       mode_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic             irq_ack,
  input logic             match_pulse,
  input logic [VAL_W-1:0] top_value,
  input logic             flag_q,
  input logic [VAL_W-1:0] active_val,
  input logic [VAL_W-1:0] shadow_val,
  input logic             commit_stb,
  input logic [VAL_W-1:0] commit_val,
  input logic             load_evt,
  input logic             flag_set
);
  import tcmp_pkg::*;

  p_hi_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_HI && !load_evt) |=> $stable(active_val));

  p_direct_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[1] && commit_stb) |=> (active_val == $past(commit_val)));

  p_pwm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] && !load_evt) |=> $stable(active_val));

  p_pwm_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (active_val == $past(shadow_val)));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_val == active_val) |=> match_pulse);

  p_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt_val == active_val) |=> !match_pulse);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag_q);

  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !flag_set) |=> !flag_q);

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && commit_stb) |=>
      (active_val == $past(shadow_val) && shadow_val == $past(commit_val)));

  generate
    if (EXPORT_TOP) begin : g_top_chk
      p_top_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (top_value == $past(active_val)));
    end
  endgenerate

endmodule

bind tcmp_channel tcmp_channel_chk #(.BUS_W(BUS_W), .EXPORT_TOP(EXPORT_TOP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .cnt_val     (cnt_val),
  .mode_sel    (mode_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .irq_ack     (irq_ack),
  .match_pulse (match_pulse),
  .top_value   (top_value),
  .flag_q      (flag_q),
  .active_val  (active_val),
  .shadow_val  (shadow_val),
  .commit_stb  (commit_stb),
  .commit_val  (commit_val),
  .load_evt    (load_evt),
  .flag_set    (flag_set)
);

// File: tb/tcmp_channel_test.sv
module tcmp_channel_test;

  localparam int  CLK_NS = 20;
  localparam int  RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        top_strobe = 1'b0;
  logic        bottom_strobe = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq;
  logic        match_pulse;
  logic [15:0] top_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench expectation state
  logic [15:0] e_act, e_shd, e_top;
  logic [7:0]  e_hold;
  logic        e_flag, e_seen, e_pulse;

  always #(CLK_NS/2) clk = ~clk;

  tcmp_channel uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
    .top_strobe(top_strobe), .bottom_strobe(bottom_strobe), .mode_sel(mode_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq),
    .match_pulse(match_pulse), .top_value(top_value)
  );

  function automatic logic [7:0] want_rdata(logic rd, logic [1:0] a, logic [15:0] act, logic fl);
    if (!rd) return 8'h00;
    case (a)
      2'd0:    return act[7:0];
      2'd1:    return act[15:8];
      2'd2:    return {7'b0, fl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic pwm_load(logic [1:0] m, logic tk, logic t, logic b);
    if (m == 2'd2) return tk && t;
    if (m == 2'd3) return tk && b;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_act = '0; e_shd = '0; e_top = '0; e_hold = '0;
    e_flag = 0; e_seen = 0; e_pulse = 0;
  endtask

  // One clock: predict, advance, compare
  task automatic step();
    logic [15:0] n_act, n_shd, cv;
    logic [7:0]  n_hold;
    logic        n_flag, n_seen, n_pulse, cm, ld, fs, clr;
    cm = bus_wr && bus_addr == 2'd0;
    cv = {e_hold, bus_wdata};
    ld = pwm_load(mode_sel, tick, top_strobe, bottom_strobe);
    n_hold = (bus_wr && bus_addr == 2'd1) ? bus_wdata : e_hold;
    n_shd  = cm ? cv : e_shd;
    if (mode_sel[1]) n_act = ld ? e_shd : e_act;
    else             n_act = cm ? cv : e_act;
    n_pulse = tick && (cnt_val == e_act);
    n_seen  = tick ? (cnt_val == e_act) : e_seen;
    fs  = tick && e_seen;
    clr = irq_ack || (bus_wr && bus_addr == 2'd2 && bus_wdata[0]);
    n_flag = fs ? 1'b1 : (clr ? 1'b0 : e_flag);
    @(posedge clk);
    #1;
    e_top = e_act;
    e_act = n_act; e_shd = n_shd; e_hold = n_hold;
    e_pulse = n_pulse; e_seen = n_seen; e_flag = n_flag;
    check("R5 match_pulse", match_pulse, e_pulse);
    check("R6 flag via irq", irq, e_flag && irq_en);
    check("R7 irq", irq, e_flag && irq_en);
    check("R11 top_value", top_value, e_top);
    check("R12 rdata", bus_rdata, want_rdata(bus_rd, bus_addr, e_act, e_flag));
  endtask

  task automatic idle();
    tick = 0; top_strobe = 0; bottom_strobe = 0; bus_wr = 0; bus_rd = 0;
    irq_ack = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    idle(); bus_wr = 1; bus_addr = a; bus_wdata = d; step(); idle();
  endtask

  task automatic rd_word(output logic [15:0] v);
    idle(); bus_rd = 1; bus_addr = 2'd0; step(); v[7:0] = bus_rdata;
    bus_addr = 2'd1; step(); v[15:8] = bus_rdata; idle();
  endtask

  task automatic rd_flag(output logic f);
    idle(); bus_rd = 1; bus_addr = 2'd2; step(); f = bus_rdata[0]; idle();
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        f;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 top_value reset", top_value, 16'h0);
    check("R1 match_pulse reset", match_pulse, 1'b0);
    rst_n = 1;
    rd_word(w);  check("R1 active reset", w, 16'h0000);
    rd_flag(f);  check("R1 flag reset", f, 1'b0);

    // R2 / R3 in free-running mode
    mode_sel = 2'd0;
    wr(2'd1, 8'hAB);
    rd_word(w);  check("R2 high byte only holds", w, 16'h0000);
    wr(2'd0, 8'hCD);
    rd_word(w);  check("R3 direct commit", w, 16'hABCD);
    mode_sel = 2'd1;
    wr(2'd1, 8'h03); wr(2'd0, 8'h04);
    rd_word(w);  check("R3 clear-on-match commit", w, 16'h0304);

    // R4 load at top
    mode_sel = 2'd2;
    wr(2'd1, 8'h12); wr(2'd0, 8'h34);
    rd_word(w);  check("R4 pwm holds before top", w, 16'h0304);
    idle(); bottom_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R4 bottom ignored in top mode", w, 16'h0304);
    idle(); top_strobe = 1; tick = 0; step(); idle();
    rd_word(w);  check("R4 strobe without tick ignored", w, 16'h0304);
    idle(); top_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R4 loaded at top", w, 16'h1234);

    // R4 load at bottom
    mode_sel = 2'd3;
    wr(2'd1, 8'h56); wr(2'd0, 8'h78);
    idle(); top_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R4 top ignored in bottom mode", w, 16'h1234);
    idle(); bottom_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R4 loaded at bottom", w, 16'h5678);

    // R10 commit on the load point
    mode_sel = 2'd2;
    wr(2'd1, 8'h11); wr(2'd0, 8'h11);
    wr(2'd1, 8'h22);
    idle(); bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h22; top_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R10 old shadow loaded", w, 16'h1111);
    idle(); top_strobe = 1; tick = 1; step(); idle();
    rd_word(w);  check("R10 new word at next point", w, 16'h2222);

    // R6 / R9: match then ack on the setting tick
    mode_sel = 2'd0; irq_en = 1;
    wr(2'd1, 8'h00); wr(2'd0, 8'h40);
    idle(); tick = 1; cnt_val = 16'h0040; step();
    check("R5 pulse after equality", match_pulse, 1'b1);
    cnt_val = 16'h0000; irq_ack = 1; step(); idle();
    check("R9 set beats clear", irq, 1'b1);
    rd_flag(f);  check("R6 flag set", f, 1'b1);

    // R8 clears
    wr(2'd2, 8'hFE);
    rd_flag(f);  check("R8 write zero ignored", f, 1'b1);
    wr(2'd2, 8'h01);
    rd_flag(f);  check("R8 write one clears", f, 1'b0);
    idle(); tick = 1; cnt_val = 16'h0040; step(); cnt_val = 16'h0; step(); idle();
    rd_flag(f);  check("R6 flag set again", f, 1'b1);
    irq_ack = 1; step(); idle();
    rd_flag(f);  check("R8 ack clears", f, 1'b0);

    // Random traffic
    for (int i = 0; i < RAND_CYCLES; i++) begin
      if (i % 64 == 0) mode_sel = 2'($urandom_range(0, 3));
      tick          = ($urandom_range(0, 3) != 0);
      top_strobe    = ($urandom_range(0, 7) == 0);
      bottom_strobe = ($urandom_range(0, 7) == 1);
      bus_wr        = ($urandom_range(0, 3) == 0);
      bus_rd        = ($urandom_range(0, 1) == 0);
      bus_addr      = 2'($urandom_range(0, 3));
      bus_wdata     = 8'($urandom);
      irq_en        = ($urandom_range(0, 1) == 0);
      irq_ack       = ($urandom_range(0, 7) == 0);
      cnt_val       = ($urandom_range(0, 2) == 0) ? e_act : 16'($urandom);
      step();
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule